// File: doc/BRIEF.md
# General-Purpose I/O Bank with Output Latch and Open-Drain Control

This block is one bank of general-purpose pins. Software reaches it through a small register interface with four registers. The first holds the output value. The second reads the live pin level, and writing it also loads the output value. The third sets each pin's direction, and the fourth turns each pin into an open-drain output. For every pin the bank produces an output-enable and an output-data signal for the pad. The level coming back from each pad passes through a multi-stage synchronizer before it can be read.

Each pin can also be handed to a peripheral. While a pin's peripheral-enable input is high, the peripheral's own data and enable replace the register values on that pin. The open-drain conversion still applies in that case. Each pin also has an analog-mode flag, which blanks the pin's digital read value. A mask parameter marks which bits of the bank exist. Absent bits read as zero everywhere and never drive their pad.

Top module: `pio_bank`

## Requirements
- R1: After reset the direction register reads all implemented bits as 1. The output value and open-drain registers read 0, and no pad output-enable is active.
- R2: With no peripheral and open-drain off, a direction bit of 0 drives the pad with output-enable 1 and data equal to the stored output bit. A direction bit of 1 gives output-enable 0.
- R3: A write to address 0 (output value) or to address 1 (pin register) loads the same output value. The new value reads back at address 0 in the cycle after the write.
- R4: A read of address 1 returns the pad input level as it stood two clock edges earlier. A read of address 0 returns the stored output value whatever the pad level is.
- R5: When a pin's open-drain bit is 1, its pad data is 0. An output bit of 1 releases the pin (output-enable 0) and an output bit of 0 pulls it low (output-enable 1), provided the pin's source enable is active.
- R6: With peripheral-enable high, the pad output-enable and data follow the peripheral's enable and data instead of the direction and output registers. Reads of address 1 still return the pad level.
- R7: The open-drain conversion of R5 also applies to the peripheral's data and enable when peripheral-enable is high.
- R8: A pin with its analog-mode flag high reads 0 at address 1.
- R9: Bits cleared in the implemented-bit mask read 0 in every register and never assert pad output-enable or pad data.
- R10: Address 2 is the direction register and address 3 is the open-drain register. With the write strobe low, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 output value, 1 pin, 2 direction, 3 open-drain |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Combinational read data for the selected register |
| pad_in | input | W | Level seen at each pad |
| pad_oe | output | W | Per-pin pad output-enable |
| pad_out | output | W | Per-pin pad output data |
| perif_en | input | W | Per-pin peripheral takeover |
| perif_oe | input | W | Peripheral output-enable per pin |
| perif_out | input | W | Peripheral output data per pin |
| ana_mode | input | W | Per-pin analog-mode flag |

## Verification
The bench runs a small configuration with one absent bit. It sweeps every output-value pattern against changing direction and open-drain settings, and checks pad enable and data against an arithmetic model. A design that drives a released open-drain pin high, or lets an absent bit reach its pad, fails here at once.

A second sweep crosses peripheral takeover with open-drain. This catches a design that applies open-drain only to register-driven pins. Pin reads are sampled one and two edges after a pad change, which catches a synchronizer that is one stage short. The sweep also mixes analog flags into those reads, and writes through the pin address, which catch a read path that ignores the analog blanking and a pin-address write that misses the output latch.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef enum logic [1:0] {
      REG_LAT = 2'd0,
      REG_PIN = 2'd1,
      REG_DIR = 2'd2,
      REG_ODR = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
   import pio_pkg::*;
#(
   parameter int           W         = 16,
   parameter logic [W-1:0] IMPL_MASK = {W{1'b1}}
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   bus_addr,
   input  logic         bus_we,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   input  logic [W-1:0] pin_lvl,
   input  logic [W-1:0] ana_mode,
   output logic [W-1:0] lat_q,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] odr_q
);
   reg_sel_e     sel;
   logic [W-1:0] wval;

   assign sel  = reg_sel_e'(bus_addr);
   assign wval = bus_wdata & IMPL_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_q <= '0;
         dir_q <= IMPL_MASK;
         odr_q <= '0;
      end else if (bus_we) begin
         case (sel)
            REG_LAT, REG_PIN: lat_q <= wval;
            REG_DIR:          dir_q <= wval;
            REG_ODR:          odr_q <= wval;
            default:          ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         REG_LAT: bus_rdata = lat_q;
         REG_PIN: bus_rdata = pin_lvl & ~ana_mode & IMPL_MASK;
         REG_DIR: bus_rdata = dir_q;
         REG_ODR: bus_rdata = odr_q;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pio_drive.sv
module pio_drive #(
   parameter int           W         = 16,
   parameter logic [W-1:0] IMPL_MASK = {W{1'b1}}
) (
   input  logic [W-1:0] lat_q,
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] odr_q,
   input  logic [W-1:0] perif_en,
   input  logic [W-1:0] perif_oe,
   input  logic [W-1:0] perif_out,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_out
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      if (IMPL_MASK[i]) begin : g_live
         logic src_oe;
         logic src_d;
         assign src_oe = perif_en[i] ? perif_oe[i]  : ~dir_q[i];
         assign src_d  = perif_en[i] ? perif_out[i] : lat_q[i];
         assign pad_oe[i]  = odr_q[i] ? (src_oe & ~src_d) : src_oe;
         assign pad_out[i] = odr_q[i] ? 1'b0 : src_d;
      end else begin : g_absent
         assign pad_oe[i]  = 1'b0;
         assign pad_out[i] = 1'b0;
      end
   end
endmodule

// File: rtl/pio_bank.sv
module pio_bank #(
   parameter int           W           = 16,
   parameter logic [W-1:0] IMPL_MASK   = {W{1'b1}},
   parameter int           SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   bus_addr,
   input  logic         bus_we,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   input  logic [W-1:0] pad_in,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_out,
   input  logic [W-1:0] perif_en,
   input  logic [W-1:0] perif_oe,
   input  logic [W-1:0] perif_out,
   input  logic [W-1:0] ana_mode
);
   if (W < 1 || W > 32) begin : g_bad_width
      $error("pio_bank: W must be 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pio_bank: SYNC_STAGES must be at least 2");
   end

   logic [W-1:0] pin_lvl;
   logic [W-1:0] lat_q;
   logic [W-1:0] dir_q;
   logic [W-1:0] odr_q;

   pio_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (pin_lvl)
   );

   pio_regs #(.W(W), .IMPL_MASK(IMPL_MASK)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pin_lvl  (pin_lvl),
      .ana_mode (ana_mode),
      .lat_q    (lat_q),
      .dir_q    (dir_q),
      .odr_q    (odr_q)
   );

   pio_drive #(.W(W), .IMPL_MASK(IMPL_MASK)) drive_i (
      .lat_q    (lat_q),
      .dir_q    (dir_q),
      .odr_q    (odr_q),
      .perif_en (perif_en),
      .perif_oe (perif_oe),
      .perif_out(perif_out),
      .pad_oe   (pad_oe),
      .pad_out  (pad_out)
   );
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
   parameter int           W    = 16,
   parameter logic [W-1:0] MASK = {W{1'b1}}
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   bus_addr,
   input logic         bus_we,
   input logic [W-1:0] bus_wdata,
   input logic [W-1:0] bus_rdata,
   input logic [W-1:0] pad_oe,
   input logic [W-1:0] pad_out,
   input logic [W-1:0] perif_en,
   input logic [W-1:0] perif_oe,
   input logic [W-1:0] ana_mode,
   input logic [W-1:0] lat_q,
   input logic [W-1:0] dir_q,
   input logic [W-1:0] odr_q
);
   AST_ABSENT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe | pad_out) & ~MASK) == '0); // R9

   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & odr_q) == '0); // R5

   AST_INPUT_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & dir_q & ~perif_en) == '0); // R2

   AST_PERIF_OE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe ^ perif_oe) & perif_en & ~odr_q & MASK) == '0); // R6

   AST_ANALOG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd1) |-> ((bus_rdata & ana_mode) == '0)); // R8

   AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[1] == 1'b0) |=> (lat_q == $past(bus_wdata & MASK))); // R3
endmodule

bind pio_bank pio_bank_chk #(.W(W), .MASK(IMPL_MASK)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .pad_oe   (pad_oe),
   .pad_out  (pad_out),
   .perif_en (perif_en),
   .perif_oe (perif_oe),
   .ana_mode (ana_mode),
   .lat_q    (lat_q),
   .dir_q    (dir_q),
   .odr_q    (odr_q)
);

// File: tb/pio_bank_tb.sv
module pio_bank_tb_top;
   localparam int           W          = 8;
   localparam logic [W-1:0] M          = 8'h7F;
   localparam time          CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [1:0]   bus_addr;
   logic         bus_we;
   logic [W-1:0] bus_wdata;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pad_in;
   logic [W-1:0] pad_oe;
   logic [W-1:0] pad_out;
   logic [W-1:0] perif_en;
   logic [W-1:0] perif_oe;
   logic [W-1:0] perif_out;
   logic [W-1:0] ana_mode;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_bank #(.W(W), .IMPL_MASK(M), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .perif_en(perif_en),
      .perif_oe(perif_oe), .perif_out(perif_out), .ana_mode(ana_mode)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0;
      #1 d = bus_rdata;
   endtask

   function automatic logic [W-1:0] exp_oe(input logic [W-1:0] dir, lat, od, pen, poe, pout);
      logic [W-1:0] so, sd;
      so = (pen & poe)  | (~pen & ~dir);
      sd = (pen & pout) | (~pen & lat);
      return ((od & so & ~sd) | (~od & so)) & M;
   endfunction

   function automatic logic [W-1:0] exp_out(input logic [W-1:0] lat, od, pen, pout);
      return ((pen & pout) | (~pen & lat)) & ~od & M;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] r, latv, dirv, odv;
      rst_n = 1'b0; bus_addr = 2'd0; bus_we = 1'b0; bus_wdata = '0;
      pad_in = '0; perif_en = '0; perif_oe = '0; perif_out = '0; ana_mode = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd(2'd0, r); chk("R1 latch reset", r, '0);
      rd(2'd2, r); chk("R1 dir reset", r, M);
      rd(2'd3, r); chk("R1 odr reset", r, '0);
      chk("R1 pad_oe reset", pad_oe, '0);

      // R10 write with strobe low changes nothing
      @(negedge clk); bus_addr = 2'd2; bus_wdata = 8'h00; bus_we = 1'b0;
      rd(2'd2, r); chk("R10 dir unchanged without strobe", r, M);

      // R2 R3 R5 R9 R10 sweep all output patterns
      for (int v = 0; v < 256; v++) begin
         latv = 8'(v);
         dirv = 8'(v) ^ 8'hC3;
         odv  = 8'(v * 5) ^ 8'h96;
         wr(v[0] ? 2'd1 : 2'd0, latv);
         wr(2'd2, dirv);
         wr(2'd3, odv);
         #1;
         chk("R2 R5 pad_oe", pad_oe, exp_oe(dirv & M, latv & M, odv & M, '0, '0, '0));
         chk("R2 R5 R9 pad_out", pad_out, exp_out(latv & M, odv & M, '0, '0));
         rd(2'd0, r); chk("R3 latch readback", r, latv & M);
         if (v % 16 == 0) begin
            rd(2'd2, r); chk("R9 R10 dir readback", r, dirv & M);
            rd(2'd3, r); chk("R9 R10 odr readback", r, odv & M);
         end
      end

      // R6 R7 peripheral takeover
      wr(2'd0, 8'h0F); wr(2'd2, 8'h33); wr(2'd3, 8'h5A);
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         perif_en = 8'(v); perif_oe = 8'(v * 3); perif_out = 8'(v * 7) ^ 8'h55;
         #1;
         chk("R6 R7 pad_oe", pad_oe, exp_oe(8'h33, 8'h0F, 8'h5A, perif_en, perif_oe, perif_out));
         chk("R6 R7 pad_out", pad_out, exp_out(8'h0F, 8'h5A, perif_en, perif_out));
      end
      @(negedge clk); perif_en = 8'hFF; pad_in = 8'hA6; bus_addr = 2'd1;
      @(negedge clk); @(negedge clk); #1;
      chk("R6 pin read under override", bus_rdata, 8'hA6 & M);

      // R4 synchronizer latency: old value after one edge, new after two
      @(negedge clk); pad_in = 8'h5B; bus_addr = 2'd1;
      @(negedge clk); #1 chk("R4 one edge still old", bus_rdata, 8'hA6 & M);
      @(negedge clk); #1 chk("R4 two edges new", bus_rdata, 8'h5B & M);
      perif_en = '0;

      // R4 R8 pin reads with analog flags; latch read independent of pad
      wr(2'd0, 8'h3C);
      for (int v = 0; v < 64; v++) begin
         @(negedge clk);
         pad_in = 8'(v * 13) ^ 8'hE1; ana_mode = 8'(v * 29); bus_addr = 2'd1;
         @(negedge clk); @(negedge clk); #1;
         chk("R4 R8 pin read", bus_rdata, pad_in & ~ana_mode & M);
         rd(2'd0, r); chk("R4 latch ignores pad", r, 8'h3C);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule